// File: doc/BRIEF.md
# Dual-Rail Bit-Serial Self-Timed Half Adder

This block adds two operand streams one bit position at a time. Each operand bit travels on a pair of complementary lines. A single-cycle pulse on the true line carries a 1, and a pulse on the false line carries a 0. The block does not use a data clock. It detects the arrival of an operand bit from the OR of that operand's two lines. When both operand bits of a position are present, it pulses one rail of the sum pair and one rail of the carry pair. The sum is the XOR of the two bits and the carry is their AND. No carry moves between positions.

The operands of one position need not arrive in the same cycle. The block holds whichever bit arrives first until its partner arrives. Two cases are flagged as encoding errors: both rails of an operand pulsing together, or a second bit arriving on an operand that still holds an unmatched bit. Each error raises a one-cycle error pulse and produces no result.

Results are collected into words of `W` bits. The most recent complete word is held. A read strobe shifts it out serially on a separate readout port.

Top module: `dr_serial_half_adder`

## Requirements
- R1: An operand bit is signalled by a one-cycle pulse on exactly one of its two lines: the true line (`*_t`) encodes 1 and the false line (`*_f`) encodes 0. The arrival event of an operand is the OR of its two lines.
- R2: For each position, the block computes sum = A xor B and carry = A and B. It pulses exactly one rail of each pair: true for 1, false for 0. Both pairs pulse in the cycle after the cycle in which the second operand bit arrived. For example, words A=0011 and B=0101 give sum 0110 and carry 0001, and A=1001 and B=1010 give sum 0011 and carry 1000.
- R3: A lone operand bit produces no output. It is held for any number of idle cycles until the other operand's bit arrives, and the result is then emitted.
- R4: If both rails of an operand pulse in the same cycle, `err` pulses in the next cycle. No sum or carry rail pulses, and any held bit of either operand is discarded.
- R5: If a bit arrives on an operand that already holds an unmatched bit, `err` pulses in the next cycle. No sum or carry rail pulses, and both held bits are discarded.
- R6: Results are shifted into a collector, and the first result of a word becomes its most significant bit. After `W` results, the collected sum and carry words replace the held words. An error does not advance the collector.
- R7: A read strobe starts a burst in the following cycle. For `W` cycles, `rd_valid` is high and `rd_sum`/`rd_carry` present the held words, most significant bit first with the default `MSB_FIRST=1`. `rd_valid` then falls.
- R8: A read strobe during a burst is ignored. A word that completes during a burst does not alter the bits still being shifted out, and it is returned by the next read.
- R9: While reset is asserted, all outputs are low. Reset clears held operand bits, the collector count and the held words, so a read after reset returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock; each pulse lasts one cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_t | input | 1 | Operand A true rail (bit = 1) |
| a_f | input | 1 | Operand A false rail (bit = 0) |
| b_t | input | 1 | Operand B true rail (bit = 1) |
| b_f | input | 1 | Operand B false rail (bit = 0) |
| rd_strobe | input | 1 | Starts a serial readout of the held words |
| sum_t | output | 1 | Sum true rail pulse |
| sum_f | output | 1 | Sum false rail pulse |
| carry_t | output | 1 | Carry true rail pulse |
| carry_f | output | 1 | Carry false rail pulse |
| err | output | 1 | Encoding error pulse |
| rd_valid | output | 1 | High while readout bits are presented |
| rd_sum | output | 1 | Serial sum word bit |
| rd_carry | output | 1 | Serial carry word bit |

## Verification
Collection of a new word and serial readout of the previous word can happen in the same cycles. The bench starts a readout and, during the burst, drives a full new word at one bit per cycle. It also raises a second strobe partway through the burst. The burst must return the old word bit by bit and end after `W` cycles. The next read must return the new word. A second overlap is between holding a lone bit and an error on the other operand. Here the bench checks at the ports that the held bit was discarded: it sends the next bit alone and expects no output.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    // arrival event recovered from one operand's rail pair
    typedef struct packed {
        logic v;      // a bit arrived this cycle
        logic val;    // its value
        logic clash;  // both rails pulsed
    } rail_ev_t;

    // state of the pairing stage
    typedef struct packed {
        logic a_h;
        logic a_val;
        logic b_h;
        logic b_val;
        logic sum_t;
        logic sum_f;
        logic carry_t;
        logic carry_f;
        logic err;
    } join_st_t;

endpackage

// File: rtl/hsa_rail_recv.sv
module hsa_rail_recv
    import hsa_pkg::*;
(
    input  logic     rail_t,
    input  logic     rail_f,
    output rail_ev_t ev
);

    always_comb begin
        ev.v     = rail_t | rail_f;
        ev.val   = rail_t;
        ev.clash = rail_t & rail_f;
    end

endmodule

// File: rtl/hsa_pair_join.sv
module hsa_pair_join
    import hsa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rail_ev_t a_ev,
    input  rail_ev_t b_ev,
    output logic     sum_t,
    output logic     sum_f,
    output logic     carry_t,
    output logic     carry_f,
    output logic     err
);

    join_st_t st_d, st_q;

    logic bad_code, overrun, a_av, b_av, a_bit, b_bit, s_bit, c_bit;

    always_comb begin
        st_d         = st_q;
        st_d.sum_t   = 1'b0;
        st_d.sum_f   = 1'b0;
        st_d.carry_t = 1'b0;
        st_d.carry_f = 1'b0;
        st_d.err     = 1'b0;

        bad_code = a_ev.clash | b_ev.clash;
        overrun  = (a_ev.v & st_q.a_h) | (b_ev.v & st_q.b_h);
        a_av     = st_q.a_h | a_ev.v;
        b_av     = st_q.b_h | b_ev.v;
        a_bit    = st_q.a_h ? st_q.a_val : a_ev.val;
        b_bit    = st_q.b_h ? st_q.b_val : b_ev.val;
        s_bit    = a_bit ^ b_bit;
        c_bit    = a_bit & b_bit;

        if (bad_code || overrun) begin
            st_d.err = 1'b1;
            st_d.a_h = 1'b0;
            st_d.b_h = 1'b0;
        end else if (a_av && b_av) begin
            st_d.sum_t   = s_bit;
            st_d.sum_f   = ~s_bit;
            st_d.carry_t = c_bit;
            st_d.carry_f = ~c_bit;
            st_d.a_h     = 1'b0;
            st_d.b_h     = 1'b0;
        end else begin
            if (a_ev.v) begin
                st_d.a_h   = 1'b1;
                st_d.a_val = a_ev.val;
            end
            if (b_ev.v) begin
                st_d.b_h   = 1'b1;
                st_d.b_val = b_ev.val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_t   = st_q.sum_t;
    assign sum_f   = st_q.sum_f;
    assign carry_t = st_q.carry_t;
    assign carry_f = st_q.carry_f;
    assign err     = st_q.err;

endmodule

// File: rtl/hsa_readout.sv
module hsa_readout #(
    parameter int W         = 4,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic res_v,
    input  logic res_s,
    input  logic res_c,
    input  logic rd_strobe,
    output logic rd_valid,
    output logic rd_sum,
    output logic rd_carry
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  col_s;
        logic [W-1:0]  col_c;
        logic [CW-1:0] ccnt;
        logic [W-1:0]  hold_s;
        logic [W-1:0]  hold_c;
        logic [W-1:0]  out_s;
        logic [W-1:0]  out_c;
        logic [CW-1:0] rcnt;
    } ro_st_t;

    ro_st_t st_d, st_q;
    logic [W-1:0] nxt_s, nxt_c;

    always_comb begin
        st_d  = st_q;
        nxt_s = (st_q.col_s << 1) | W'(res_s);
        nxt_c = (st_q.col_c << 1) | W'(res_c);

        // collection side
        if (res_v) begin
            if (st_q.ccnt == CW'(W - 1)) begin
                st_d.hold_s = nxt_s;
                st_d.hold_c = nxt_c;
                st_d.ccnt   = '0;
                st_d.col_s  = '0;
                st_d.col_c  = '0;
            end else begin
                st_d.col_s = nxt_s;
                st_d.col_c = nxt_c;
                st_d.ccnt  = st_q.ccnt + CW'(1);
            end
        end

        // readout side
        if (st_q.rcnt != '0) begin
            if (MSB_FIRST) begin
                st_d.out_s = st_q.out_s << 1;
                st_d.out_c = st_q.out_c << 1;
            end else begin
                st_d.out_s = st_q.out_s >> 1;
                st_d.out_c = st_q.out_c >> 1;
            end
            st_d.rcnt = st_q.rcnt - CW'(1);
        end else if (rd_strobe) begin
            st_d.out_s = st_q.hold_s;
            st_d.out_c = st_q.hold_c;
            st_d.rcnt  = CW'(W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (MSB_FIRST) begin : g_msb
            assign rd_sum   = (st_q.rcnt != '0) & st_q.out_s[W-1];
            assign rd_carry = (st_q.rcnt != '0) & st_q.out_c[W-1];
        end else begin : g_lsb
            assign rd_sum   = (st_q.rcnt != '0) & st_q.out_s[0];
            assign rd_carry = (st_q.rcnt != '0) & st_q.out_c[0];
        end
    endgenerate

    assign rd_valid = (st_q.rcnt != '0);

endmodule

// File: rtl/dr_serial_half_adder.sv
module dr_serial_half_adder
    import hsa_pkg::*;
#(
    parameter int W         = 4,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_t,
    input  logic a_f,
    input  logic b_t,
    input  logic b_f,
    input  logic rd_strobe,
    output logic sum_t,
    output logic sum_f,
    output logic carry_t,
    output logic carry_f,
    output logic err,
    output logic rd_valid,
    output logic rd_sum,
    output logic rd_carry
);

    localparam int NOPS = 2;

    logic [NOPS-1:0] tr, fr;
    rail_ev_t        ev [NOPS];

    assign tr = {b_t, a_t};
    assign fr = {b_f, a_f};

    generate
        for (genvar k = 0; k < NOPS; k++) begin : g_rx
            hsa_rail_recv u_rx (
                .rail_t (tr[k]),
                .rail_f (fr[k]),
                .ev     (ev[k])
            );
        end
    endgenerate

    hsa_pair_join u_join (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_ev    (ev[0]),
        .b_ev    (ev[1]),
        .sum_t   (sum_t),
        .sum_f   (sum_f),
        .carry_t (carry_t),
        .carry_f (carry_f),
        .err     (err)
    );

    hsa_readout #(.W(W), .MSB_FIRST(MSB_FIRST)) u_ro (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_v     (sum_t | sum_f),
        .res_s     (sum_t),
        .res_c     (carry_t),
        .rd_strobe (rd_strobe),
        .rd_valid  (rd_valid),
        .rd_sum    (rd_sum),
        .rd_carry  (rd_carry)
    );

endmodule

// File: rtl/hsa_checker.sv
module hsa_checker #(
    parameter int W = 4
) (
    input logic clk,
    input logic rst_n,
    input logic a_t,
    input logic a_f,
    input logic b_t,
    input logic b_f,
    input logic rd_strobe,
    input logic sum_t,
    input logic sum_f,
    input logic carry_t,
    input logic carry_f,
    input logic err,
    input logic rd_valid
);

    localparam int RW = $clog2(W + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (rd_valid) begin
            if (run_q != RW'(W + 1)) run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    p_rail_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sum_t && sum_f) && !(carry_t && carry_f));

    p_pair_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_t || sum_f) == (carry_t || carry_f));

    p_out_needs_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_t || sum_f) |-> $past(a_t || a_f || b_t || b_f));

    p_clash_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_t && a_f) || (b_t && b_f)) |=> (err && !sum_t && !sum_f));

    p_no_out_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !(sum_t || sum_f || carry_t || carry_f));

    p_rd_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(rd_strobe));

    p_rd_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(W));

endmodule

bind dr_serial_half_adder hsa_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_t       (a_t),
    .a_f       (a_f),
    .b_t       (b_t),
    .b_f       (b_f),
    .rd_strobe (rd_strobe),
    .sum_t     (sum_t),
    .sum_f     (sum_f),
    .carry_t   (carry_t),
    .carry_f   (carry_f),
    .err       (err),
    .rd_valid  (rd_valid)
);

// File: tb/dr_serial_half_adder_tb.sv
module dr_serial_half_adder_tb;

    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_t = 0, a_f = 0, b_t = 0, b_f = 0, rd_strobe = 0;
    logic sum_t, sum_f, carry_t, carry_f, err, rd_valid, rd_sum, rd_carry;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dr_serial_half_adder #(.W(W), .MSB_FIRST(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .rd_strobe(rd_strobe),
        .sum_t(sum_t), .sum_f(sum_f), .carry_t(carry_t), .carry_f(carry_f),
        .err(err), .rd_valid(rd_valid), .rd_sum(rd_sum), .rd_carry(rd_carry)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int outs();
        return {28'd0, sum_t, sum_f, carry_t, carry_f};
    endfunction

    task automatic chk_quiet(input string tag);
        chk(outs() == 0 && err == 1'b0, tag, {outs(), 3'b0, err}, 0);
    endtask

    task automatic drive(input logic at, input logic af, input logic bt, input logic bf);
        a_t = at; a_f = af; b_t = bt; b_f = bf;
        @(negedge clk);
        a_t = 0; a_f = 0; b_t = 0; b_f = 0;
    endtask

    // mode 0: same cycle, 1: A first, 2: B first; gap = idle-inclusive spacing
    task automatic send_bit(input logic ab, input logic bb, input int mode, input int gap);
        logic s, c;
        s = ab ^ bb;
        c = ab & bb;
        if (mode == 0) begin
            drive(ab, !ab, bb, !bb);
        end else begin
            if (mode == 1) drive(ab, !ab, 0, 0);
            else           drive(0, 0, bb, !bb);
            chk_quiet("R3 lone bit emits nothing");
            for (int g = 1; g < gap; g++) begin
                @(negedge clk);
                chk_quiet("R3 held bit waits");
            end
            if (mode == 1) drive(0, 0, bb, !bb);
            else           drive(ab, !ab, 0, 0);
        end
        chk(outs() == {s, !s, c, !c} && !err, "R2 R1 rails for bit",
            outs(), {s, !s, c, !c});
    endtask

    task automatic send_word(input logic [W-1:0] aw, input logic [W-1:0] bw, input int seed);
        for (int i = W - 1; i >= 0; i--) begin
            send_bit(aw[i], bw[i], (seed + i) % 3, 1 + ((seed + 2 * i) % 3));
        end
    endtask

    task automatic read_word(output logic [W-1:0] s, output logic [W-1:0] c);
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        for (int i = 0; i < W; i++) begin
            chk(rd_valid == 1'b1, "R7 rd_valid during burst", rd_valid, 1);
            s[W-1-i] = rd_sum;
            c[W-1-i] = rd_carry;
            @(negedge clk);
        end
        chk(rd_valid == 1'b0, "R7 burst length", rd_valid, 0);
    endtask

    task automatic word_test(input logic [W-1:0] aw, input logic [W-1:0] bw, input int seed,
                             input string tag);
        logic [W-1:0] s, c;
        send_word(aw, bw, seed);
        read_word(s, c);
        chk(s == (aw ^ bw), tag, s, aw ^ bw);
        chk(c == (aw & bw), tag, c, aw & bw);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(outs() == 0 && !err && !rd_valid && !rd_sum && !rd_carry,
            "R9 outputs low in reset", {outs(), err, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] s1, c1, s2, c2, aw2, bw2;

        @(negedge clk);
        do_reset();
        read_word(s1, c1);
        chk(s1 == 0 && c1 == 0, "R9 held words cleared", {s1, c1}, 0);

        // R4: clash on A while B held; B must be discarded
        drive(0, 0, 1, 0);
        chk_quiet("R3 lone B");
        drive(1, 1, 0, 0);
        chk(err == 1'b1 && outs() == 0, "R4 clash raises err, no output", {outs(), err}, 1);
        drive(1, 0, 0, 0);
        chk_quiet("R4 held B discarded");
        drive(0, 0, 1, 0);
        chk(outs() == 4'b0110 && !err, "R4 fresh pair after clash", outs(), 4'b0110);

        // R4: clash on B with A valid in same cycle
        drive(1, 0, 1, 1);
        chk(err == 1'b1 && outs() == 0, "R4 clash on B", {outs(), err}, 1);

        // R5: second A before B
        drive(0, 1, 0, 0);
        chk_quiet("R3 lone A");
        drive(1, 0, 0, 0);
        chk(err == 1'b1 && outs() == 0, "R5 overrun raises err", {outs(), err}, 1);
        drive(0, 0, 0, 1);
        chk_quiet("R5 holds cleared after overrun");
        drive(0, 1, 0, 0);
        chk(outs() == 4'b0101 && !err, "R5 fresh pair after overrun", outs(), 4'b0101);

        // R9: reset mid-word clears collector
        do_reset();
        word_test(4'b0011, 4'b0101, 0, "R2 R6 example one");
        word_test(4'b1001, 4'b1010, 1, "R2 R6 example two");

        // R6: errors do not advance the collector
        send_bit(1'b1, 1'b1, 0, 1);
        drive(1, 1, 0, 0);
        chk(err == 1'b1, "R6 error mid-word", err, 1);
        send_bit(1'b0, 1'b1, 1, 2);
        send_bit(1'b1, 1'b0, 2, 1);
        send_bit(1'b0, 1'b0, 0, 1);
        read_word(s1, c1);
        chk(s1 == 4'b0110 && c1 == 4'b1000, "R6 error does not advance",
            {s1, c1}, {4'b0110, 4'b1000});

        // R8: new word collected during burst, extra strobe ignored
        word_test(4'b1100, 4'b0110, 2, "R6 word before overlap");
        aw2 = 4'b0111;
        bw2 = 4'b1101;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        for (int i = 0; i < W; i++) begin
            chk(rd_valid == 1'b1, "R8 burst continues", rd_valid, 1);
            s1[W-1-i] = rd_sum;
            c1[W-1-i] = rd_carry;
            a_t = aw2[W-1-i]; a_f = !aw2[W-1-i];
            b_t = bw2[W-1-i]; b_f = !bw2[W-1-i];
            rd_strobe = (i == 1);
            @(negedge clk);
            a_t = 0; a_f = 0; b_t = 0; b_f = 0; rd_strobe = 0;
        end
        chk(rd_valid == 1'b0, "R8 strobe during burst ignored", rd_valid, 0);
        chk(s1 == (4'b1100 ^ 4'b0110) && c1 == (4'b1100 & 4'b0110),
            "R8 burst returns old word", {s1, c1}, {4'b1010, 4'b0100});
        read_word(s2, c2);
        chk(s2 == (aw2 ^ bw2) && c2 == (aw2 & bw2), "R8 next read returns new word",
            {s2, c2}, {aw2 ^ bw2, aw2 & bw2});

        // exhaustive sweep over all operand word pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                word_test(W'(a), W'(b), a * 7 + b, "R2 R6 R7 sweep word");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired (R7 run did not end) actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule